// File: doc/BRIEF.md
# Crosspoint Switch Configuration Controller

This block is the digital control plane of an 8-output by 8-input crosspoint matrix. Each output owns a 5-bit setting made of an enable bit, a 3-bit input index and one reserved bit. The block turns the eight settings into a one-hot input select per output and a per-output enable. The analog switches and the output buffers sit outside the block.

Settings are programmed in one of two modes, chosen by a mode pin. In serial mode, a 40-bit shift chain reloads every output at once. The bit leaving the far end of the chain appears on a data-out pin, so several devices can be chained and fed from one stream. In parallel mode, an output address and a 4-bit data value rewrite a single output and leave the other seven alone. Both modes write a pending (first) rank. An update strobe copies that rank into a live (second) rank, and only the live rank drives the selects. Every input is sampled on the system clock. The programming clock is treated as a rising-edge event in serial mode and as a level in parallel mode.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, every enable and every select is 0 and data-out is 0.
- R2: In serial mode, with chip enable high, each rising edge of the programming clock shifts one bit into the pending rank. A 40-bit word is sent most significant bit first. Output 7's field goes first and output 0's field goes last. Inside each field the order is enable, then index bit 2 down to bit 0, then the reserved bit. After an update, output k follows the field that was sent.
- R3: After the n-th serial shift edge, data-out shows the bit shifted in at edge n-39. Before 40 edges have occurred it shows 0.
- R4: In serial mode, holding the programming clock high for several cycles shifts only once.
- R5: In parallel mode, with chip enable high, each cycle in which the programming clock is high writes the output selected by the 3-bit address. Data bit 3 becomes the enable, data bits 2..0 become the input index, and the reserved bit is cleared. The other seven fields keep their values.
- R6: The live rank, and so every output, changes only in the cycle after a cycle in which both update and chip enable are high. It then equals the pending rank of that cycle.
- R7: For an enabled output k with index i, select bit 8k+i is 1 and the other seven bits of that output are 0, and enable bit k is 1. For a disabled output, all eight select bits and the enable are 0. The reserved bit has no effect.
- R8: While chip enable is low, the programming clock and the update strobe have no effect in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; all outputs disabled |
| ce_i | input | 1 | Chip enable for programming clock and update |
| ser_mode_i | input | 1 | 1 = serial mode, 0 = parallel mode |
| prog_clk_i | input | 1 | Programming clock (edge in serial, level in parallel) |
| sdin_i | input | 1 | Serial data in |
| sdout_o | output | 1 | Serial data out to the next device in a chain |
| addr_i | input | 3 | Parallel output address |
| pdata_i | input | 4 | Parallel data: bit 3 enable, bits 2..0 input index |
| upd_i | input | 1 | Update strobe, copies pending rank to live rank |
| sel_o | output | 64 | One-hot input selects, output k at bits 8k+7..8k |
| en_o | output | 8 | Output enables |

## Verification
The parallel path is swept over every address and every input index, first with the enable set and then with it cleared. This separates decode errors, wrong-output writes and a leaking disabled output. The serial path gets several 40-bit words: random words, a word with only the reserved bits set, and a word that gives each output a distinct index. These expose field-order and bit-order swaps, and a second word shifted behind the first checks data-out bit by bit. Separate runs hold the programming clock high, program without an update, and toggle everything with chip enable low. These tell apart edge and level sensitivity, rank separation and chip-enable gating.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
    localparam int unsigned DEF_OUTS = 8;
    localparam int unsigned DEF_INS  = 8;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } xpt_mode_e;
endpackage

// File: rtl/xpt_first_rank.sv
module xpt_first_rank #(
    parameter int unsigned NUM_OUT = xpt_cfg_pkg::DEF_OUTS,
    parameter int unsigned NUM_IN  = xpt_cfg_pkg::DEF_INS,
    localparam int unsigned IDX_W  = $clog2(NUM_IN),
    localparam int unsigned FLD_W  = IDX_W + 2,
    localparam int unsigned WORD_W = NUM_OUT * FLD_W,
    localparam int unsigned ADR_W  = $clog2(NUM_OUT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_i,
    input  logic              ser_mode_i,
    input  logic              pclk_i,
    input  logic              sdin_i,
    input  logic [ADR_W-1:0]  addr_i,
    input  logic [IDX_W:0]    pdata_i,
    output logic [WORD_W-1:0] word_o,
    output logic              sdout_o
);
    import xpt_cfg_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              pclk_prev;
    } state_t;

    state_t st_d, st_q;
    logic   ser_edge, par_wr;

    assign ser_edge = ce_i && (xpt_mode_e'(ser_mode_i) == MODE_SER) && pclk_i && !st_q.pclk_prev;
    assign par_wr   = ce_i && (xpt_mode_e'(ser_mode_i) == MODE_PAR) && pclk_i;

    always_comb begin
        st_d           = st_q;
        st_d.pclk_prev = pclk_i;
        if (ser_edge) begin
            st_d.word = {st_q.word[WORD_W-2:0], sdin_i};
        end else if (par_wr) begin
            for (int k = 0; k < int'(NUM_OUT); k++) begin
                if (addr_i == ADR_W'(k)) begin
                    st_d.word[k*FLD_W +: FLD_W] = {pdata_i, 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign sdout_o = st_q.word[WORD_W-1];

    // R8: no chip enable, no change to the pending rank
    a_r8_ce_gates_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ce_i |=> $stable(word_o));

    // R4: clock held high in serial mode does not shift again
    a_r4_single_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_i && ser_mode_i && pclk_i && st_q.pclk_prev) |=> $stable(word_o));

    // R3: data-out moves one place along the chain per shift edge
    a_r3_dout_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_i && ser_mode_i && pclk_i && !st_q.pclk_prev) |=> (sdout_o == $past(word_o[WORD_W-2])));

    generate
        for (genvar g = 0; g < int'(NUM_OUT); g++) begin : g_fld_chk
            // R5: other fields untouched, addressed field takes the data
            a_r5_other_fields_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (par_wr && addr_i != ADR_W'(g)) |=> $stable(word_o[g*FLD_W +: FLD_W]));
            a_r5_field_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (par_wr && addr_i == ADR_W'(g)) |=> (word_o[g*FLD_W +: FLD_W] == {$past(pdata_i), 1'b0}));
        end
    endgenerate
endmodule

// File: rtl/xpt_second_rank.sv
module xpt_second_rank #(
    parameter int unsigned WORD_W = 40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_i,
    input  logic              upd_i,
    input  logic [WORD_W-1:0] pend_i,
    output logic [WORD_W-1:0] live_o
);
    typedef struct packed {
        logic [WORD_W-1:0] live;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ce_i && upd_i) st_d.live = pend_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign live_o = st_q.live;

    // R6: update copies the pending rank one cycle later
    a_r6_update_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_i && upd_i) |=> (live_o == $past(pend_i)));
    // R6 / R8: without a qualified update the live rank holds
    a_r6_live_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ce_i && upd_i) |=> $stable(live_o));
endmodule

// File: rtl/xpt_out_decode.sv
module xpt_out_decode #(
    parameter int unsigned NUM_IN = xpt_cfg_pkg::DEF_INS,
    localparam int unsigned IDX_W = $clog2(NUM_IN)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [NUM_IN-1:0] sel_o,
    output logic              en_o
);
    always_comb begin
        sel_o = '0;
        if (en_i && (int'(idx_i) < int'(NUM_IN))) sel_o[idx_i] = 1'b1;
    end

    assign en_o = en_i;

    // R7: at most one input per output, none when disabled
    a_r7_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(sel_o));
    a_r7_off_no_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_o |-> (sel_o == '0));
    a_r7_on_one_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o |-> ($countones(sel_o) == 1));
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl #(
    parameter int unsigned NUM_OUT = xpt_cfg_pkg::DEF_OUTS,
    parameter int unsigned NUM_IN  = xpt_cfg_pkg::DEF_INS,
    localparam int unsigned IDX_W  = $clog2(NUM_IN),
    localparam int unsigned FLD_W  = IDX_W + 2,
    localparam int unsigned WORD_W = NUM_OUT * FLD_W,
    localparam int unsigned ADR_W  = $clog2(NUM_OUT)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      ce_i,
    input  logic                      ser_mode_i,
    input  logic                      prog_clk_i,
    input  logic                      sdin_i,
    output logic                      sdout_o,
    input  logic [ADR_W-1:0]          addr_i,
    input  logic [IDX_W:0]            pdata_i,
    input  logic                      upd_i,
    output logic [NUM_OUT*NUM_IN-1:0] sel_o,
    output logic [NUM_OUT-1:0]        en_o
);
    logic [WORD_W-1:0]  pend_w;
    logic [WORD_W-1:0]  live_w;
    logic [NUM_OUT-1:0] unused_rsv;

    xpt_first_rank #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) first_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ce_i       (ce_i),
        .ser_mode_i (ser_mode_i),
        .pclk_i     (prog_clk_i),
        .sdin_i     (sdin_i),
        .addr_i     (addr_i),
        .pdata_i    (pdata_i),
        .word_o     (pend_w),
        .sdout_o    (sdout_o)
    );

    xpt_second_rank #(.WORD_W(WORD_W)) second_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ce_i   (ce_i),
        .upd_i  (upd_i),
        .pend_i (pend_w),
        .live_o (live_w)
    );

    generate
        for (genvar k = 0; k < int'(NUM_OUT); k++) begin : g_out
            assign unused_rsv[k] = live_w[k*FLD_W];
            xpt_out_decode #(.NUM_IN(NUM_IN)) dec_i (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .en_i   (live_w[k*FLD_W + FLD_W - 1]),
                .idx_i  (live_w[k*FLD_W + 1 +: IDX_W]),
                .sel_o  (sel_o[k*NUM_IN +: NUM_IN]),
                .en_o   (en_o[k])
            );
        end
    endgenerate

    // R1: outputs come out of reset disabled
    a_r1_reset_off: assert property (@(posedge clk_i)
        !rst_ni |=> (en_o == '0 || rst_ni));
endmodule

// File: tb/xpt_cfg_ctrl_tb_top.sv
module xpt_cfg_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0, ser = 1'b0, pclk = 1'b0, sdin = 1'b0, upd = 1'b0;
    logic [2:0]  addr = '0;
    logic [3:0]  pdata = '0;
    logic        sdout;
    logic [63:0] sel;
    logic [7:0]  en;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [39:0] m_pend = '0, m_live = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xpt_cfg_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .ser_mode_i(ser), .prog_clk_i(pclk),
        .sdin_i(sdin), .sdout_o(sdout), .addr_i(addr), .pdata_i(pdata), .upd_i(upd),
        .sel_o(sel), .en_o(en)
    );

    function automatic logic [63:0] exp_sel(input logic [39:0] w);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++) if (w[k*5+4]) r[k*8 + int'(w[k*5+1 +: 3])] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] exp_en(input logic [39:0] w);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = w[k*5+4];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " sel"}, sel, exp_sel(m_live));
        chk({req, " en"}, {56'd0, en}, {56'd0, exp_en(m_live)});
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); sdin = b; pclk = 1'b1;
        @(negedge clk); pclk = 1'b0;
        if (ce && ser) m_pend = {m_pend[38:0], b};
    endtask

    task automatic par_write(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk); addr = a; pdata = d; pclk = 1'b1;
        @(negedge clk); pclk = 1'b0;
        if (ce && !ser) m_pend[a*5 +: 5] = {d, 1'b0};
    endtask

    task automatic do_update();
        @(negedge clk); upd = 1'b1;
        @(negedge clk); upd = 1'b0;
        if (ce) m_live = m_pend;
    endtask

    task automatic send_word(input logic [39:0] w, input string req);
        for (int b = 39; b >= 0; b--) begin
            shift_bit(w[b]);
            chk(req, {63'd0, sdout}, {63'd0, m_pend[39]});  // R3
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sel", sel, '0);
        chk("R1 reset en", {56'd0, en}, '0);
        chk("R1 reset dout", {63'd0, sdout}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_outputs("R1 after reset");

        // R5 / R7: parallel sweep, enabled then disabled
        ce = 1'b1; ser = 1'b0;
        for (int a = 0; a < 8; a++) begin
            for (int i = 0; i < 8; i++) begin
                par_write(3'(a), {1'b1, 3'(i)});
                do_update();
                chk_outputs("R5 R7 parallel enabled");
            end
        end
        for (int a = 0; a < 8; a++) begin
            par_write(3'(a), {1'b0, 3'(7 - a)});
            do_update();
            chk_outputs("R5 R7 parallel disabled");
        end

        // R6: no update, no change
        par_write(3'd0, 4'b1011);
        par_write(3'd6, 4'b1101);
        repeat (3) @(negedge clk);
        chk_outputs("R6 pending not live");
        do_update();
        chk_outputs("R6 after update");

        // R8: chip enable low blocks everything
        ce = 1'b0;
        par_write(3'd1, 4'b1110);
        do_update();
        chk_outputs("R8 ce low parallel");
        ser = 1'b1;
        shift_bit(1'b1); shift_bit(1'b0);
        do_update();
        chk_outputs("R8 ce low serial");
        ce = 1'b1; ser = 1'b0;
        do_update();
        chk_outputs("R8 pending kept");

        // R2 / R3: serial words
        ser = 1'b1;
        send_word({$urandom, $urandom} & 40'hFF_FFFF_FFFF, "R3 dout word1");
        do_update(); chk_outputs("R2 serial random1");
        send_word(40'h08_4210_8421, "R3 dout word2");
        do_update(); chk_outputs("R2 reserved only");
        send_word({5'b11110, 5'b11100, 5'b11010, 5'b11000, 5'b10110, 5'b10100, 5'b10010, 5'b10000},
                  "R3 dout word3");
        do_update(); chk_outputs("R2 distinct indices");
        send_word({$urandom, $urandom} & 40'hFF_FFFF_FFFF, "R3 dout word4");
        do_update(); chk_outputs("R2 serial random2");

        // R4: hold high shifts once
        @(negedge clk); sdin = 1'b1; pclk = 1'b1;
        repeat (4) @(negedge clk);
        sdin = 1'b0;
        repeat (2) @(negedge clk);
        pclk = 1'b0;
        m_pend = {m_pend[38:0], 1'b1};
        chk("R4 dout after hold", {63'd0, sdout}, {63'd0, m_pend[39]});
        do_update(); chk_outputs("R4 single shift");

        // R1: reset mid-operation
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        m_pend = '0; m_live = '0;
        chk_outputs("R1 reset again");
        chk("R1 reset dout again", {63'd0, sdout}, '0);
        rst_n = 1'b1;
        do_update(); chk_outputs("R1 pending cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule